// File: doc/BRIEF.md
# Masked Multi-Bus Break Comparator

This block is a single channel of a debug break-condition unit. Software programs a reference address, an address mask, a reference data word and a small bus-select field through a plain register port. On every clock the channel looks at one chosen bus out of four: two full-width buses (the instruction-side bus "I" and the local bus "L") and two half-width memory buses ("X" and "Y"). When a valid transfer on that bus has a matching address and matching data, the channel raises a one-cycle pulse on its match output.

An address bit takes part in the comparison only when its mask bit is clear. The data comparison always uses the full reference word for the I and L buses. A transfer on the X bus is compared with the upper half of the reference data, and a transfer on the Y bus with the lower half. The half that is not used has no effect. Interrupt generation, chaining between channels and access-type qualifiers are handled elsewhere. This channel only produces the raw match pulse.

Top module: `brk_cmp_chan`

## Requirements
- R1: While reset is asserted and right after it, the match output is 0 and all four registers read back as zero. A zero control field means the channel is disabled.
- R2: A write with `reg_we`=1 updates the register at `reg_addr` on the next clock edge. The offsets are 0 for the reference address, 1 for the mask and 2 for the reference data, each holding 32 bits. Offset 3 is the control field, which keeps only bits 3:0 and reads bits 31:4 as 0. `reg_rdata` shows the addressed register combinationally.
- R3: The control bits are bus code [1:0], half-bus enable [2] and half-bus choice [3]. With bit 2 = 0, code 01 selects I and code 10 selects L. Codes 00 and 11 disable the channel, and it then never matches.
- R4: With control bit 2 = 1, bit 3 = 0 selects the X bus and bit 3 = 1 selects the Y bus, whatever the bus code is.
- R5: The address condition holds when ((bus address XOR reference address) AND NOT mask) is zero. A mask bit of 1 removes that address bit from the comparison.
- R6: When I or L is selected, all 32 bus data bits must equal the 32 reference data bits.
- R7: When X is selected, X data bits 15:0 must equal reference data bits 31:16. Reference bits 15:0 have no effect.
- R8: When Y is selected, Y data bits 15:0 must equal reference data bits 15:0. Reference bits 31:16 have no effect.
- R9: A match needs the valid strobe of the selected bus. Strobes, addresses and data on the buses that are not selected have no effect.
- R10: The match output is registered. It is high for exactly the one cycle after each qualifying transfer, so back-to-back qualifying transfers give back-to-back pulses.
- R11: A register write in the same cycle as a transfer does not change that transfer's outcome. The new value applies from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| i_vld | input | 1 | I bus transfer valid |
| i_addr | input | 32 | I bus address |
| i_data | input | 32 | I bus data |
| l_vld | input | 1 | L bus transfer valid |
| l_addr | input | 32 | L bus address |
| l_data | input | 32 | L bus data |
| x_vld | input | 1 | X memory bus transfer valid |
| x_addr | input | 32 | X memory bus address |
| x_data | input | 16 | X memory bus data |
| y_vld | input | 1 | Y memory bus transfer valid |
| y_addr | input | 32 | Y memory bus address |
| y_data | input | 16 | Y memory bus data |
| match_o | output | 1 | One-cycle break-match pulse |

## Verification
The assertions assume that reset is asserted from time zero and held for at least one edge. They also assume that every bus input is driven to a known value on each edge, because the address and data checks sample the selected bus one cycle before a pulse. The stimulus drives all inputs only on the falling clock edge and never leaves them undriven. It holds reset from the very start and returns strobes and write enables to zero after each step. The random phase draws bus addresses close to the programmed reference so that masked matches actually occur.

// File: rtl/brk_pkg.sv
package brk_pkg;

    // Register offsets on the register port
    typedef enum logic [1:0] {
        OFS_REF_ADDR = 2'd0,
        OFS_ADDR_MSK = 2'd1,
        OFS_REF_DATA = 2'd2,
        OFS_CTRL     = 2'd3
    } reg_ofs_e;

    // Which bus feeds the comparison
    typedef enum logic [2:0] {
        SRC_OFF = 3'd0,
        SRC_I   = 3'd1,
        SRC_L   = 3'd2,
        SRC_X   = 3'd3,
        SRC_Y   = 3'd4
    } bus_src_e;

    localparam int CTRL_W      = 4;
    localparam int CTRL_CODE_LO = 0;
    localparam int CTRL_HB_EN  = 2;
    localparam int CTRL_HB_SEL = 3;

    // Control field decode: half-bus enable overrides the bus code
    function automatic bus_src_e ctrl_to_src(input logic [CTRL_W-1:0] ctl);
        bus_src_e s;
        if (ctl[CTRL_HB_EN]) begin
            s = ctl[CTRL_HB_SEL] ? SRC_Y : SRC_X;
        end else begin
            unique case (ctl[CTRL_CODE_LO +: 2])
                2'b01:   s = SRC_I;
                2'b10:   s = SRC_L;
                default: s = SRC_OFF;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/brk_regfile.sv
module brk_regfile
    import brk_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        ofs,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [ADDR_W-1:0] ref_addr,
    output logic [ADDR_W-1:0] addr_msk,
    output logic [DATA_W-1:0] ref_data,
    output logic [CTRL_W-1:0] ctrl
);

    typedef struct packed {
        logic [ADDR_W-1:0] ref_addr;
        logic [ADDR_W-1:0] addr_msk;
        logic [DATA_W-1:0] ref_data;
        logic [CTRL_W-1:0] ctrl;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            unique case (reg_ofs_e'(ofs))
                OFS_REF_ADDR: cfg_d.ref_addr = wdata[ADDR_W-1:0];
                OFS_ADDR_MSK: cfg_d.addr_msk = wdata[ADDR_W-1:0];
                OFS_REF_DATA: cfg_d.ref_data = wdata[DATA_W-1:0];
                OFS_CTRL:     cfg_d.ctrl     = wdata[CTRL_W-1:0];
                default:      cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        unique case (reg_ofs_e'(ofs))
            OFS_REF_ADDR: rdata[ADDR_W-1:0] = cfg_q.ref_addr;
            OFS_ADDR_MSK: rdata[ADDR_W-1:0] = cfg_q.addr_msk;
            OFS_REF_DATA: rdata[DATA_W-1:0] = cfg_q.ref_data;
            OFS_CTRL:     rdata[CTRL_W-1:0] = cfg_q.ctrl;
            default:      rdata = '0;
        endcase
    end

    assign ref_addr = cfg_q.ref_addr;
    assign addr_msk = cfg_q.addr_msk;
    assign ref_data = cfg_q.ref_data;
    assign ctrl     = cfg_q.ctrl;

endmodule

// File: rtl/brk_bus_sel.sv
module brk_bus_sel
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              i_vld,
    input  logic [ADDR_W-1:0] i_addr,
    input  logic [DATA_W-1:0] i_data,
    input  logic              l_vld,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_data,
    input  logic              x_vld,
    input  logic [ADDR_W-1:0] x_addr,
    input  logic [HALF_W-1:0] x_data,
    input  logic              y_vld,
    input  logic [ADDR_W-1:0] y_addr,
    input  logic [HALF_W-1:0] y_data,
    output logic              sel_vld,
    output logic [ADDR_W-1:0] sel_addr,
    output logic [DATA_W-1:0] sel_data,
    output logic [DATA_W-1:0] sel_care
);

    localparam logic [HALF_W-1:0] HALF_ONES = '1;
    localparam logic [HALF_W-1:0] HALF_ZERO = '0;

    bus_src_e src;

    always_comb begin
        src      = ctrl_to_src(ctrl);
        sel_vld  = 1'b0;
        sel_addr = '0;
        sel_data = '0;
        sel_care = '0;
        unique case (src)
            SRC_I: begin
                sel_vld  = i_vld;
                sel_addr = i_addr;
                sel_data = i_data;
                sel_care = '1;
            end
            SRC_L: begin
                sel_vld  = l_vld;
                sel_addr = l_addr;
                sel_data = l_data;
                sel_care = '1;
            end
            SRC_X: begin
                // X lines up with the upper half of the reference word
                sel_vld  = x_vld;
                sel_addr = x_addr;
                sel_data = {x_data, HALF_ZERO};
                sel_care = {HALF_ONES, HALF_ZERO};
            end
            SRC_Y: begin
                // Y lines up with the lower half of the reference word
                sel_vld  = y_vld;
                sel_addr = y_addr;
                sel_data = {HALF_ZERO, y_data};
                sel_care = {HALF_ZERO, HALF_ONES};
            end
            default: begin
                sel_vld = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/brk_match.sv
module brk_match #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              vld,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic [ADDR_W-1:0] addr_msk,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] care,
    input  logic [DATA_W-1:0] ref_data,
    output logic              hit
);

    logic [ADDR_W-1:0] addr_diff;
    logic [DATA_W-1:0] data_diff;
    logic              addr_ok;
    logic              data_ok;

    // Per-bit difference with the excluded bits cleared
    for (genvar b = 0; b < ADDR_W; b++) begin : g_abit
        assign addr_diff[b] = (addr[b] ^ ref_addr[b]) & ~addr_msk[b];
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_dbit
        assign data_diff[b] = (data[b] ^ ref_data[b]) & care[b];
    end

    assign addr_ok = ~|addr_diff;
    assign data_ok = ~|data_diff;
    assign hit     = vld & addr_ok & data_ok;

endmodule

// File: rtl/brk_cmp_chan.sv
module brk_cmp_chan
    import brk_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              i_vld,
    input  logic [ADDR_W-1:0] i_addr,
    input  logic [DATA_W-1:0] i_data,
    input  logic              l_vld,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_data,
    input  logic              x_vld,
    input  logic [ADDR_W-1:0] x_addr,
    input  logic [HALF_W-1:0] x_data,
    input  logic              y_vld,
    input  logic [ADDR_W-1:0] y_addr,
    input  logic [HALF_W-1:0] y_data,
    output logic              match_o
);

    logic [ADDR_W-1:0] cfg_ref_addr;
    logic [ADDR_W-1:0] cfg_addr_msk;
    logic [DATA_W-1:0] cfg_ref_data;
    logic [CTRL_W-1:0] cfg_ctrl;

    logic              sel_vld;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_data;
    logic [DATA_W-1:0] sel_care;
    logic              hit;

    typedef struct packed {
        logic pulse;
    } out_t;

    out_t out_d, out_q;

    brk_regfile #(
        .REG_W (REG_W),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .ofs     (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .ref_addr(cfg_ref_addr),
        .addr_msk(cfg_addr_msk),
        .ref_data(cfg_ref_data),
        .ctrl    (cfg_ctrl)
    );

    brk_bus_sel #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_sel (
        .ctrl    (cfg_ctrl),
        .i_vld   (i_vld),
        .i_addr  (i_addr),
        .i_data  (i_data),
        .l_vld   (l_vld),
        .l_addr  (l_addr),
        .l_data  (l_data),
        .x_vld   (x_vld),
        .x_addr  (x_addr),
        .x_data  (x_data),
        .y_vld   (y_vld),
        .y_addr  (y_addr),
        .y_data  (y_data),
        .sel_vld (sel_vld),
        .sel_addr(sel_addr),
        .sel_data(sel_data),
        .sel_care(sel_care)
    );

    brk_match #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_cmp (
        .vld     (sel_vld),
        .addr    (sel_addr),
        .ref_addr(cfg_ref_addr),
        .addr_msk(cfg_addr_msk),
        .data    (sel_data),
        .care    (sel_care),
        .ref_data(cfg_ref_data),
        .hit     (hit)
    );

    always_comb begin
        out_d       = out_q;
        out_d.pulse = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign match_o = out_q.pulse;

endmodule

// File: rtl/brk_cmp_chk.sv
module brk_cmp_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int REG_W  = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              match_o,
    input logic              reg_we,
    input logic [1:0]        reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              i_vld,
    input logic              l_vld,
    input logic              x_vld,
    input logic              y_vld,
    input logic [ADDR_W-1:0] i_addr,
    input logic [ADDR_W-1:0] l_addr,
    input logic [ADDR_W-1:0] x_addr,
    input logic [ADDR_W-1:0] y_addr,
    input logic [HALF_W-1:0] x_data,
    input logic [HALF_W-1:0] y_data,
    input logic [ADDR_W-1:0] cfg_ref_addr,
    input logic [ADDR_W-1:0] cfg_addr_msk,
    input logic [DATA_W-1:0] cfg_ref_data,
    input logic [3:0]        cfg_ctrl
);

    logic want_i, want_l, want_x, want_y, off;
    logic [ADDR_W-1:0] chk_addr;
    logic              chk_vld;

    assign want_x = cfg_ctrl[2] && !cfg_ctrl[3];
    assign want_y = cfg_ctrl[2] &&  cfg_ctrl[3];
    assign want_i = !cfg_ctrl[2] && (cfg_ctrl[1:0] == 2'b01);
    assign want_l = !cfg_ctrl[2] && (cfg_ctrl[1:0] == 2'b10);
    assign off    = !(want_i || want_l || want_x || want_y);

    assign chk_vld  = (want_i && i_vld) || (want_l && l_vld) ||
                      (want_x && x_vld) || (want_y && y_vld);
    assign chk_addr = want_i ? i_addr : want_l ? l_addr :
                      want_x ? x_addr : y_addr;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!match_o && cfg_ctrl == 4'd0 && cfg_ref_data == '0));

    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd3) |=> (cfg_ctrl == $past(reg_wdata[3:0])));

    assert_off_no_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        off |=> !match_o);

    assert_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> $past(chk_vld));

    assert_addr_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> ((($past(chk_addr) ^ $past(cfg_ref_addr)) & ~$past(cfg_addr_msk)) == '0));

    assert_x_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && $past(want_x)) |-> ($past(x_data) == $past(cfg_ref_data[DATA_W-1:HALF_W])));

    assert_y_lower_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && $past(want_y)) |-> ($past(y_data) == $past(cfg_ref_data[HALF_W-1:0])));

endmodule

bind brk_cmp_chan brk_cmp_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .REG_W (REG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .match_o     (match_o),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .i_vld       (i_vld),
    .l_vld       (l_vld),
    .x_vld       (x_vld),
    .y_vld       (y_vld),
    .i_addr      (i_addr),
    .l_addr      (l_addr),
    .x_addr      (x_addr),
    .y_addr      (y_addr),
    .x_data      (x_data),
    .y_data      (y_data),
    .cfg_ref_addr(cfg_ref_addr),
    .cfg_addr_msk(cfg_addr_msk),
    .cfg_ref_data(cfg_ref_data),
    .cfg_ctrl    (cfg_ctrl)
);

// File: tb/brk_cmp_chan_tb.sv
module brk_cmp_chan_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        i_vld = 1'b0, l_vld = 1'b0, x_vld = 1'b0, y_vld = 1'b0;
    logic [31:0] i_addr = '0, l_addr = '0, x_addr = '0, y_addr = '0;
    logic [31:0] i_data = '0, l_data = '0;
    logic [15:0] x_data = '0, y_data = '0;
    logic        match_o;

    int total = 0;
    int bad   = 0;

    // reference model state
    logic [31:0] m_addr = '0, m_msk = '0, m_data = '0;
    logic [3:0]  m_ctl = '0;

    always #10 clk = ~clk;

    brk_cmp_chan u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .i_vld(i_vld), .i_addr(i_addr), .i_data(i_data),
        .l_vld(l_vld), .l_addr(l_addr), .l_data(l_data),
        .x_vld(x_vld), .x_addr(x_addr), .x_data(x_data),
        .y_vld(y_vld), .y_addr(y_addr), .y_data(y_data),
        .match_o(match_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic model_hit();
        logic        v;
        logic [31:0] a;
        logic        d;
        if (m_ctl[2]) begin
            if (!m_ctl[3]) begin v = x_vld; a = x_addr; d = (x_data == m_data[31:16]); end
            else           begin v = y_vld; a = y_addr; d = (y_data == m_data[15:0]);  end
        end else if (m_ctl[1:0] == 2'b01) begin
            v = i_vld; a = i_addr; d = (i_data == m_data);
        end else if (m_ctl[1:0] == 2'b10) begin
            v = l_vld; a = l_addr; d = (l_data == m_data);
        end else begin
            return 1'b0;
        end
        return v && (((a ^ m_addr) & ~m_msk) == 32'd0) && d;
    endfunction

    // one clock: predict from pre-edge state, update model, compare at negedge
    task automatic tick(input string req);
        logic exp;
        exp = model_hit();
        @(posedge clk);
        if (reg_we) begin
            case (reg_addr)
                2'd0: m_addr = reg_wdata;
                2'd1: m_msk  = reg_wdata;
                2'd2: m_data = reg_wdata;
                default: m_ctl = reg_wdata[3:0];
            endcase
        end
        @(negedge clk);
        chk(req, {31'd0, match_o}, {31'd0, exp});
        reg_we = 1'b0;
        i_vld = 1'b0; l_vld = 1'b0; x_vld = 1'b0; y_vld = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick("R2");
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    // drive a transfer and expect a given pulse value
    task automatic expect_pulse(input string req, input logic e);
        logic m;
        m = model_hit();
        chk({req, "-model"}, {31'd0, m}, {31'd0, e});
        tick(req);
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset
        @(negedge clk);
        chk("R1", {31'd0, match_o}, 32'd0);
        rd("R1", 2'd0, 32'd0); rd("R1", 2'd1, 32'd0);
        rd("R1", 2'd2, 32'd0); rd("R1", 2'd3, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        i_vld = 1'b1; tick("R1");   // channel off after reset

        // R2: write and read back
        wr(2'd0, 32'h1234_5678); rd("R2", 2'd0, 32'h1234_5678);
        wr(2'd1, 32'h0000_00F0); rd("R2", 2'd1, 32'h0000_00F0);
        wr(2'd2, 32'hCAFE_BEEF); rd("R2", 2'd2, 32'hCAFE_BEEF);
        wr(2'd3, 32'hFFFF_FFF1); rd("R2", 2'd3, 32'h0000_0001);

        // R6: I bus, full data compare; R5 mask
        i_vld = 1'b1; i_addr = 32'h1234_5678; i_data = 32'hCAFE_BEEF; expect_pulse("R6", 1'b1);
        i_vld = 1'b1; i_data = 32'hCAFE_BEEE; expect_pulse("R6", 1'b0);
        i_vld = 1'b1; i_data = 32'hCAFE_BEEF; i_addr = 32'h1234_5608; expect_pulse("R5", 1'b1);
        i_vld = 1'b1; i_addr = 32'h1234_5679; expect_pulse("R5", 1'b0);
        i_vld = 1'b0; i_addr = 32'h1234_5678; expect_pulse("R9", 1'b0);
        // R9: strobe on unselected bus
        l_vld = 1'b1; l_addr = 32'h1234_5678; l_data = 32'hCAFE_BEEF; expect_pulse("R9", 1'b0);

        // L bus
        wr(2'd3, 32'h2);
        l_vld = 1'b1; expect_pulse("R3", 1'b1);
        l_vld = 1'b1; l_data = 32'h4AFE_BEEF; expect_pulse("R6", 1'b0);

        // R3: disabled codes
        wr(2'd3, 32'h3);
        i_vld = 1'b1; l_vld = 1'b1; l_data = 32'hCAFE_BEEF; expect_pulse("R3", 1'b0);
        wr(2'd3, 32'h0);
        i_vld = 1'b1; l_vld = 1'b1; expect_pulse("R3", 1'b0);

        // R7: X bus uses upper half; lower half of reference ignored
        wr(2'd3, 32'h7);   // half enable with code 11: still X
        x_vld = 1'b1; x_addr = 32'h1234_5678; x_data = 16'hCAFE; expect_pulse("R7", 1'b1);
        wr(2'd2, 32'hCAFE_0000);
        x_vld = 1'b1; expect_pulse("R7", 1'b1);
        x_vld = 1'b1; x_data = 16'h0000; expect_pulse("R7", 1'b0);
        y_vld = 1'b1; y_addr = 32'h1234_5678; y_data = 16'hCAFE; expect_pulse("R4", 1'b0);

        // R8: Y bus uses lower half; upper half ignored
        wr(2'd3, 32'hC);
        wr(2'd2, 32'h1111_BEEF);
        y_vld = 1'b1; y_data = 16'hBEEF; expect_pulse("R8", 1'b1);
        y_vld = 1'b1; y_data = 16'h1111; expect_pulse("R8", 1'b0);
        x_vld = 1'b1; x_data = 16'hBEEF; expect_pulse("R4", 1'b0);

        // R10: back-to-back pulses, then idle
        y_vld = 1'b1; y_data = 16'hBEEF; expect_pulse("R10", 1'b1);
        y_vld = 1'b1; expect_pulse("R10", 1'b1);
        expect_pulse("R10", 1'b0);

        // R11: write during a matching transfer
        y_vld = 1'b1; reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h0000_0001;
        expect_pulse("R11", 1'b1);
        y_vld = 1'b1; expect_pulse("R11", 1'b0);

        // random phase against the model
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 5) == 0) begin
                reg_we = 1'b1; reg_addr = 2'($urandom_range(0, 3));
                reg_wdata = (reg_addr == 2'd1) ? ($urandom & 32'h0000_0F0F) :
                            (reg_addr == 2'd2) ? {16'hA5A5, 16'h5A5A} : $urandom;
                if (reg_addr == 2'd0) reg_wdata = 32'h8000_0000 | ($urandom & 32'h0000_00FF);
            end
            i_vld = 1'($urandom); l_vld = 1'($urandom);
            x_vld = 1'($urandom); y_vld = 1'($urandom);
            i_addr = 32'h8000_0000 | ($urandom & 32'h0000_00FF);
            l_addr = 32'h8000_0000 | ($urandom & 32'h0000_00FF);
            x_addr = 32'h8000_0000 | ($urandom & 32'h0000_00FF);
            y_addr = 32'h8000_0000 | ($urandom & 32'h0000_00FF);
            i_data = ($urandom_range(0, 1) == 0) ? 32'hA5A5_5A5A : $urandom;
            l_data = ($urandom_range(0, 1) == 0) ? 32'hA5A5_5A5A : $urandom;
            x_data = ($urandom_range(0, 1) == 0) ? 16'hA5A5 : 16'($urandom);
            y_data = ($urandom_range(0, 1) == 0) ? 16'h5A5A : 16'($urandom);
            tick("R10");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule